// File: doc/BRIEF.md
# DSP Address Generation Unit

This unit produces data-memory effective addresses for a signal-processing core. It keeps a small bank of pointer registers. Each pointer has its own step register and its own circular-buffer base and length registers. On each request it picks one pointer and applies one of eight addressing modes. It returns the effective address together with the value the pointer holds after the update. Every register in the bank is written through one load port, which selects the register kind and the index.

The core sends a mode, a primary pointer index, a secondary index (used only by the indexed mode) and a field width for bit-reversed stepping. The effective address is registered. The pointer write-back commits on the same clock edge, so requests on consecutive cycles build on each other. In circular mode the pointer wraps into its buffer at both ends, so a delay line needs no data movement. In bit-reversed mode, stepping through an FFT-sized field visits the indices in mirrored-bit order.

Top module: `agu_top`

## Requirements
- R1: After reset, `ea_valid` is 0, `ea` and `upd_val` are 0, and every pointer, step, base and length register holds 0.
- R2: A request sampled on a clock edge drives `ea`, `upd_val` and a one-cycle `ea_valid` pulse from that edge on. With no request, `ea_valid` is 0.
- R3: Mode 0 (post-increment) and mode 1 (post-decrement) return the pointer's old value as `ea` and store old+1 or old-1, modulo 2^AW.
- R4: Mode 2 (post-modify) returns the old pointer and stores old plus the paired step register, read as two's complement, modulo 2^AW.
- R5: Mode 3 (pre-decrement) stores old-1 and returns that decremented value as `ea`.
- R6: Mode 4 (indexed) returns pointer[idx] + pointer[idx2] modulo 2^AW and changes neither pointer. `upd_val` shows pointer[idx] unchanged.
- R7: Mode 5 (circular) with a non-negative step s below the length L returns the old pointer and stores old+s. When that sum reaches base+L or beyond, it stores old+s-L instead.
- R8: Mode 5 with a negative step whose magnitude is below L stores old+s+L when old+s falls below base, and stores old+s otherwise. A length of 0 turns off wrapping.
- R9: Mode 6 (bit-reversed) returns the old pointer and increments the low `rev_bits` bits with the carry running from bit `rev_bits`-1 toward bit 0. Higher bits are kept. From 0 with `rev_bits`=3 the addresses run 0,4,2,6,1,5,3,7 and then back to 0.
- R10: A load with `ld_kind` 0 (pointer), 1 (step), 2 (base) or 3 (length) writes `ld_data` to register `ld_idx` on the clock edge. If a pointer load and a request's write-back target the same pointer on the same edge, the load wins.
- R11: Mode 7 (plain indirect) returns the pointer as `ea` and does not change it.
- R12: Requests held on consecutive cycles each see the pointer value written by the request before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Address request strobe |
| mode | input | 3 | Addressing mode 0..7 |
| idx | input | $clog2(NREG) | Primary pointer index |
| idx2 | input | $clog2(NREG) | Secondary pointer index for indexed mode |
| rev_bits | input | $clog2(AW+1) | Field width for bit-reversed stepping |
| ld_en | input | 1 | Register load strobe |
| ld_kind | input | 2 | Load target: 0 pointer, 1 step, 2 base, 3 length |
| ld_idx | input | $clog2(NREG) | Load register index |
| ld_data | input | AW | Load value |
| ea | output | AW | Registered effective address |
| upd_val | output | AW | Registered pointer value after the update |
| ea_valid | output | 1 | One-cycle strobe marking `ea` and `upd_val` |

## Verification
The hardest cases to reach are the two circular wrap edges. For the forward edge, the step must carry the pointer past base+L. For the backward edge, a negative step must carry it below base, and a step that lands exactly on base must not wrap. The bench sets up a buffer whose length is not a multiple of the step, so a burst of forward requests crosses the top end with a nonzero overshoot. It then loads a negative step, starts close to the base, and checks the case that wraps and the case that lands on base. A pointer load is also issued on the same edge as that pointer's write-back, which shows the load-over-update priority.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_POSTINC = 3'd0,
    AM_POSTDEC = 3'd1,
    AM_POSTMOD = 3'd2,
    AM_PREDEC  = 3'd3,
    AM_INDEXED = 3'd4,
    AM_CIRC    = 3'd5,
    AM_BITREV  = 3'd6,
    AM_PLAIN   = 3'd7
  } agu_mode_e;

  typedef enum logic [1:0] {
    LK_PTR  = 2'd0,
    LK_STEP = 2'd1,
    LK_BASE = 2'd2,
    LK_LEN  = 2'd3
  } agu_ld_kind_e;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  input  logic [IW-1:0] rd_idx2,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] ptr2_q,
  output logic [AW-1:0] step_q,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] len_q,
  input  logic          ld_en,
  input  logic [1:0]    ld_kind,
  input  logic [IW-1:0] ld_idx,
  input  logic [AW-1:0] ld_data,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic [AW-1:0] upd_data
);
  import agu_pkg::*;

  logic [AW-1:0] ptr_r  [NREG];
  logic [AW-1:0] step_r [NREG];
  logic [AW-1:0] base_r [NREG];
  logic [AW-1:0] len_r  [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic hit_ld;
    logic hit_upd;
    assign hit_ld  = ld_en && (ld_idx == IW'(i));
    assign hit_upd = upd_en && (upd_idx == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_r[i]  <= '0;
        step_r[i] <= '0;
        base_r[i] <= '0;
        len_r[i]  <= '0;
      end else begin
        // a pointer load overrides the write-back of the same pointer
        if (hit_ld && ld_kind == LK_PTR) ptr_r[i] <= ld_data;
        else if (hit_upd)                ptr_r[i] <= upd_data;
        if (hit_ld && ld_kind == LK_STEP) step_r[i] <= ld_data;
        if (hit_ld && ld_kind == LK_BASE) base_r[i] <= ld_data;
        if (hit_ld && ld_kind == LK_LEN)  len_r[i]  <= ld_data;
      end
    end
  end

  assign ptr_q  = ptr_r[rd_idx];
  assign ptr2_q = ptr_r[rd_idx2];
  assign step_q = step_r[rd_idx];
  assign base_q = base_r[rd_idx];
  assign len_q  = len_r[rd_idx];
endmodule

// File: rtl/agu_calc.sv
module agu_calc #(
  parameter int AW  = 16,
  localparam int RBW = $clog2(AW + 1)
) (
  input  logic [2:0]     mode,
  input  logic [AW-1:0]  ptr,
  input  logic [AW-1:0]  ptr2,
  input  logic [AW-1:0]  step,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  len,
  input  logic [RBW-1:0] rev_bits,
  output logic [AW-1:0]  ea_c,
  output logic [AW-1:0]  nxt_c,
  output logic           wr_en_c
);
  import agu_pkg::*;

  // circular step: wrap by the length at either buffer end
  function automatic logic [AW-1:0] circ_step(input logic [AW-1:0] cur,
      input logic [AW-1:0] s, input logic [AW-1:0] b, input logic [AW-1:0] l);
    logic signed [AW+1:0] c, st, bb, ll, n;
    c  = $signed({2'b00, cur});
    st = $signed({{2{s[AW-1]}}, s});
    bb = $signed({2'b00, b});
    ll = $signed({2'b00, l});
    n  = c + st;
    if (l != '0) begin
      if (!s[AW-1] && n >= bb + ll) n = n - ll;
      else if (s[AW-1] && n < bb)   n = n + ll;
    end
    return n[AW-1:0];
  endfunction

  // reverse-carry increment over the low nb bits
  function automatic logic [AW-1:0] rev_inc(input logic [AW-1:0] v,
      input logic [RBW-1:0] nb);
    logic [AW-1:0] r;
    logic          c;
    r = v;
    c = 1'b1;
    for (int k = AW - 1; k >= 0; k--) begin
      if (k < int'(nb)) begin
        r[k] = v[k] ^ c;
        c    = v[k] & c;
      end
    end
    return r;
  endfunction

  always_comb begin
    ea_c    = ptr;
    nxt_c   = ptr;
    wr_en_c = 1'b1;
    unique case (agu_mode_e'(mode))
      AM_POSTINC: nxt_c = ptr + 1'b1;
      AM_POSTDEC: nxt_c = ptr - 1'b1;
      AM_POSTMOD: nxt_c = ptr + step;
      AM_PREDEC: begin
        nxt_c = ptr - 1'b1;
        ea_c  = ptr - 1'b1;
      end
      AM_INDEXED: begin
        ea_c    = ptr + ptr2;
        wr_en_c = 1'b0;
      end
      AM_CIRC:   nxt_c = circ_step(ptr, step, base, len);
      AM_BITREV: nxt_c = rev_inc(ptr, rev_bits);
      AM_PLAIN:  wr_en_c = 1'b0;
      default:   wr_en_c = 1'b0;
    endcase
  end
endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG),
  localparam int RBW = $clog2(AW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic [2:0]     mode,
  input  logic [IW-1:0]  idx,
  input  logic [IW-1:0]  idx2,
  input  logic [RBW-1:0] rev_bits,
  input  logic           ld_en,
  input  logic [1:0]     ld_kind,
  input  logic [IW-1:0]  ld_idx,
  input  logic [AW-1:0]  ld_data,
  output logic [AW-1:0]  ea,
  output logic [AW-1:0]  upd_val,
  output logic           ea_valid
);
  import agu_pkg::*;

  logic [AW-1:0] ptr_q, ptr2_q, step_q, base_q, len_q;
  logic [AW-1:0] ea_c, nxt_c;
  logic          wr_en_c;
  logic          upd_fire;
  logic          ld_hits_ptr;
  logic          started;

  agu_regfile #(.AW(AW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(idx), .rd_idx2(idx2),
    .ptr_q(ptr_q), .ptr2_q(ptr2_q), .step_q(step_q), .base_q(base_q), .len_q(len_q),
    .ld_en(ld_en), .ld_kind(ld_kind), .ld_idx(ld_idx), .ld_data(ld_data),
    .upd_en(upd_fire), .upd_idx(idx), .upd_data(nxt_c)
  );

  agu_calc #(.AW(AW)) u_calc (
    .mode(mode), .ptr(ptr_q), .ptr2(ptr2_q), .step(step_q), .base(base_q),
    .len(len_q), .rev_bits(rev_bits),
    .ea_c(ea_c), .nxt_c(nxt_c), .wr_en_c(wr_en_c)
  );

  assign upd_fire    = req && wr_en_c;
  assign ld_hits_ptr = ld_en && (ld_kind == LK_PTR) && (ld_idx == idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea       <= '0;
      upd_val  <= '0;
      ea_valid <= 1'b0;
      started  <= 1'b0;
    end else begin
      started  <= 1'b1;
      ea_valid <= req;
      if (req) begin
        ea      <= ea_c;
        upd_val <= nxt_c;
      end
    end
  end

  // named events for the circular range check
  logic [AW:0] circ_lo, circ_hi, circ_cur, circ_nxt, step_mag;
  logic        circ_event;
  assign circ_lo    = {1'b0, base_q};
  assign circ_hi    = {1'b0, base_q} + {1'b0, len_q};
  assign circ_cur   = {1'b0, ptr_q};
  assign circ_nxt   = {1'b0, nxt_c};
  assign step_mag   = step_q[AW-1] ? {1'b0, -step_q} : {1'b0, step_q};
  assign circ_event = req && (mode == AM_CIRC) && (len_q != '0) && (step_mag < {1'b0, len_q})
                      && (circ_cur >= circ_lo) && (circ_cur < circ_hi) && (circ_hi[AW] == 1'b0);

  AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (ea_valid == $past(req))); // R2
  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == AM_POSTINC) |=> (upd_val == ea + 1'b1)); // R3
  AST_PREDEC_EA: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == AM_PREDEC) |=> (ea == upd_val)); // R5
  AST_INDEXED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (mode == AM_INDEXED || mode == AM_PLAIN)) |-> !upd_fire); // R6
  AST_CIRC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    circ_event |-> ((circ_nxt >= circ_lo) && (circ_nxt < circ_hi))); // R7
  AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ld_hits_ptr) |=> (ea_valid && $past(req))); // R10
endmodule

// File: tb/tb_agu_top.sv
module tb_agu_top;
  localparam int AW = 16;
  localparam int NREG = 8;
  localparam int IW = $clog2(NREG);
  localparam int RBW = $clog2(AW + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req = 1'b0;
  logic [2:0]     mode = '0;
  logic [IW-1:0]  idx = '0, idx2 = '0, ld_idx = '0;
  logic [RBW-1:0] rev_bits = '0;
  logic           ld_en = 1'b0;
  logic [1:0]     ld_kind = '0;
  logic [AW-1:0]  ld_data = '0;
  logic [AW-1:0]  ea, upd_val;
  logic           ea_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  agu_top #(.AW(AW), .NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .idx(idx), .idx2(idx2),
    .rev_bits(rev_bits), .ld_en(ld_en), .ld_kind(ld_kind), .ld_idx(ld_idx),
    .ld_data(ld_data), .ea(ea), .upd_val(upd_val), .ea_valid(ea_valid)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] kind, input int r, input logic [AW-1:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_kind = kind; ld_idx = IW'(r); ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // single request, checked on the negedge after the capturing edge
  task automatic one_req(input string tag, input logic [2:0] m, input int r, input int r2,
                         input logic [AW-1:0] exp_ea, input logic [AW-1:0] exp_upd);
    @(negedge clk);
    req = 1'b1; mode = m; idx = IW'(r); idx2 = IW'(r2);
    @(negedge clk);
    req = 1'b0;
    chk({tag, " valid"}, AW'(ea_valid), AW'(1));
    chk({tag, " ea"}, ea, exp_ea);
    chk({tag, " upd"}, upd_val, exp_upd);
  endtask

  task automatic t_reset();
    chk("R1 ea_valid", AW'(ea_valid), '0);
    chk("R1 ea", ea, '0);
    chk("R1 upd", upd_val, '0);
    one_req("R1 ptr3 zero", 3'd7, 3, 0, 16'h0000, 16'h0000);
    one_req("R1 step zero", 3'd2, 2, 0, 16'h0000, 16'h0000);
  endtask

  task automatic t_latency();
    @(negedge clk);
    chk("R2 idle valid", AW'(ea_valid), '0);
    load(0, 0, 16'h0300);
    one_req("R2 pulse", 3'd7, 0, 0, 16'h0300, 16'h0300);
    @(negedge clk);
    chk("R2 pulse ends", AW'(ea_valid), '0);
  endtask

  task automatic t_incdec();
    load(0, 1, 16'h0010);
    one_req("R3 postinc", 3'd0, 1, 0, 16'h0010, 16'h0011);
    one_req("R3 postdec", 3'd1, 1, 0, 16'h0011, 16'h0010);
    load(0, 1, 16'hFFFF);
    one_req("R3 inc wrap", 3'd0, 1, 0, 16'hFFFF, 16'h0000);
    one_req("R3 dec wrap", 3'd1, 1, 0, 16'h0000, 16'hFFFF);
  endtask

  task automatic t_postmod();
    load(0, 2, 16'h0100);
    load(1, 2, 16'h0005);
    one_req("R4 +5", 3'd2, 2, 0, 16'h0100, 16'h0105);
    load(1, 2, 16'hFFFD);
    one_req("R4 -3", 3'd2, 2, 0, 16'h0105, 16'h0102);
  endtask

  task automatic t_predec();
    load(0, 3, 16'h0020);
    one_req("R5 predec", 3'd3, 3, 0, 16'h001F, 16'h001F);
    one_req("R5 predec again", 3'd3, 3, 0, 16'h001E, 16'h001E);
  endtask

  task automatic t_indexed();
    load(0, 4, 16'h1000);
    load(0, 5, 16'h0234);
    one_req("R6 indexed", 3'd4, 4, 5, 16'h1234, 16'h1000);
    one_req("R6 ptr4 kept", 3'd7, 4, 0, 16'h1000, 16'h1000);
    one_req("R6 ptr5 kept", 3'd7, 5, 0, 16'h0234, 16'h0234);
    load(0, 5, 16'hF100);
    one_req("R6 sum wraps", 3'd4, 4, 5, 16'h0100, 16'h1000);
  endtask

  task automatic t_circ_fwd();
    logic [AW-1:0] exp_ea [4] = '{16'h0040, 16'h0043, 16'h0046, 16'h0041};
    logic [AW-1:0] exp_up [4] = '{16'h0043, 16'h0046, 16'h0041, 16'h0044};
    load(2, 6, 16'h0040);
    load(3, 6, 16'h0008);
    load(1, 6, 16'h0003);
    load(0, 6, 16'h0040);
    @(negedge clk);
    req = 1'b1; mode = 3'd5; idx = IW'(6);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i == 3) req = 1'b0;
      chk($sformatf("R7 R12 circ fwd %0d ea", i), ea, exp_ea[i]);
      chk($sformatf("R7 R12 circ fwd %0d upd", i), upd_val, exp_up[i]);
    end
  endtask

  task automatic t_circ_bwd();
    load(1, 6, 16'hFFFD);
    load(0, 6, 16'h0041);
    one_req("R8 wrap low", 3'd5, 6, 0, 16'h0041, 16'h0046);
    one_req("R8 no wrap", 3'd5, 6, 0, 16'h0046, 16'h0043);
    one_req("R8 land base", 3'd5, 6, 0, 16'h0043, 16'h0040);
    load(3, 6, 16'h0000);
    one_req("R8 len zero linear", 3'd5, 6, 0, 16'h0040, 16'h003D);
  endtask

  task automatic t_bitrev();
    int seq [8] = '{0, 4, 2, 6, 1, 5, 3, 7};
    rev_bits = RBW'(3);
    load(0, 7, 16'h0100);
    for (int i = 0; i < 8; i++)
      one_req($sformatf("R9 bitrev step %0d", i), 3'd6, 7, 0,
              16'h0100 | AW'(seq[i]), 16'h0100 | AW'(seq[(i + 1) % 8]));
  endtask

  task automatic t_load_prio();
    load(0, 1, 16'h0030);
    @(negedge clk);
    req = 1'b1; mode = 3'd0; idx = IW'(1);
    ld_en = 1'b1; ld_kind = 2'd0; ld_idx = IW'(1); ld_data = 16'h0055;
    @(negedge clk);
    req = 1'b0; ld_en = 1'b0;
    chk("R10 old ea", ea, 16'h0030);
    one_req("R10 load wins", 3'd7, 1, 0, 16'h0055, 16'h0055);
  endtask

  task automatic t_plain();
    load(0, 0, 16'hBEEF);
    one_req("R11 plain", 3'd7, 0, 0, 16'hBEEF, 16'hBEEF);
    one_req("R11 plain kept", 3'd7, 0, 0, 16'hBEEF, 16'hBEEF);
  endtask

  task automatic t_chain();
    load(0, 2, 16'h0200);
    @(negedge clk);
    req = 1'b1; mode = 3'd0; idx = IW'(2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (i == 2) req = 1'b0;
      chk($sformatf("R12 chain %0d", i), ea, 16'h0200 + AW'(i));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_incdec();
    t_postmod();
    t_predec();
    t_indexed();
    t_circ_fwd();
    t_circ_bwd();
    t_bitrev();
    t_load_prio();
    t_plain();
    t_chain();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule